// File: doc/BRIEF.md
# Processor halt power-state controller

This block is the control state machine that takes a processor core into its low-power halt state and keeps it there. When a halt instruction retires, the controller first asks the bus for a special cycle that carries a halt message. Only after the bus acknowledges that cycle does it gate power to the core logic. While asleep it stays clocked by the running bus clock and keeps two functions alive: recognition of interrupt-class events and servicing of bus snoops.

A snoop, a cache flush or a stop-clock request takes the controller out of sleep for a short while, and it always goes back to sleep when the work is done. A snoop presents the captured address to every cache for one lookup cycle and drives the combined hit and hit-modified result in the next cycle. A flush walks every line index, writes back the dirty lines, and then issues one invalidate-all pulse. A stop-clock request parks the controller in a stop-grant state for as long as the request is held.

Only an interrupt-class event returns the core to normal execution. The power gates are released one cycle before normal execution resumes. A return from the system-management handler can also land directly in sleep when the resumed instruction is a halt. Requests that arrive while the controller is busy are latched and served in a fixed priority order. The asynchronous reset forces normal execution and clears every latch.

Top module: `halt_pwr_ctrl`

## Requirements
- R1: A `halt_retire` pulse in normal execution raises `spc_req` in the next cycle. `spc_req` stays high, with `pwr_gate_en` low, until `spc_ack` is sampled high.
- R2: `pwr_gate_en` rises in the cycle after `spc_ack` is sampled, and `spc_req` falls in that same cycle. The gates never rise without a prior acknowledge or a halt-landing handler return.
- R3: `pwr_gate_en` stays high throughout sleep, snoop service, flush service and stop grant.
- R4: A snoop in sleep drives all `cache_lookup` bits high for exactly one cycle, with `lookup_addr` equal to the captured `snoop_addr`. In the next cycle `snp_rsp_vld` is high, `snp_hit` is the OR of `cache_hit` and `snp_hitm` is the OR of `cache_hitm`. The controller then returns to sleep.
- R5: Any bit of `irq_evt` (bit 0 handler-entry interrupt, 1 bus-init, 2 INIT, 3 NMI, 4 INTR) in sleep drops `pwr_gate_en` in the next cycle. Normal execution, in which a new halt is accepted, follows one cycle later.
- R6: In normal execution, `smi_ret` with `smi_ret_halt` high raises `pwr_gate_en` in the next cycle without any `spc_req`. With `smi_ret_halt` low, the controller stays in normal execution with the gates off.
- R7: A flush in sleep steps `flush_idx` from 0 to LINES-1, one index per cycle. `wb_stb` is high exactly in the cycles where `line_dirty` is high. One single-cycle `inval_all` pulse follows, and then the controller is back in sleep.
- R8: `stpclk` in sleep raises `stop_gnt` in the next cycle. `stop_gnt` is held while `stpclk` stays high and falls one cycle after `stpclk` drops, back to sleep with the gates on.
- R9: When requests arrive together in sleep, an interrupt event wins over stop-clock, stop-clock over flush, and flush over snoop.
- R10: An interrupt event that arrives during a snoop lookup does not cut the snoop short. The response cycle and the return to sleep happen first, and the wake follows.
- R11: `rst_n` low asynchronously forces normal execution with every output low, and discards any snoop or flush request latched before reset.
- R12: Snoop, flush and interrupt inputs that arrive during normal execution are ignored and are not served after a later entry into sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; keeps running during sleep |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_retire | input | 1 | Pulse: a halt instruction retired |
| spc_ack | input | 1 | Bus completion of the halt-message special cycle |
| spc_req | output | 1 | Request for the halt-message special cycle |
| smi_ret | input | 1 | Pulse: the system-management handler returned |
| smi_ret_halt | input | 1 | With `smi_ret`: the resumed instruction is a halt |
| irq_evt | input | NUM_EVT | Interrupt-class wake events |
| stpclk | input | 1 | Stop-clock request level |
| stop_gnt | output | 1 | Stop-grant acknowledge |
| flush_req | input | 1 | Cache flush request pulse |
| flush_idx | output | IDX_W | Line index being walked by the flush |
| line_dirty | input | 1 | Dirty flag of the line at `flush_idx` |
| wb_stb | output | 1 | Write back the line at `flush_idx` |
| inval_all | output | 1 | Invalidate-all pulse ending a flush |
| snoop_req | input | 1 | Snoop request pulse from another bus agent |
| snoop_addr | input | AW | Snooped address, valid with `snoop_req` |
| cache_lookup | output | NUM_CACHES | Per-cache snoop lookup strobe |
| lookup_addr | output | AW | Address presented for the lookup |
| cache_hit | input | NUM_CACHES | Per-cache hit result, valid the cycle after lookup |
| cache_hitm | input | NUM_CACHES | Per-cache hit-modified result, same timing |
| snp_rsp_vld | output | 1 | Snoop response valid |
| snp_hit | output | 1 | Combined snoop hit |
| snp_hitm | output | 1 | Combined snoop hit-modified |
| pwr_gate_en | output | 1 | Core logic power gates applied |

## Verification
The assertions assume that `cache_hit` and `cache_hitm` are meaningful only in the response cycle. They also assume that `snoop_addr` is stable with `snoop_req`, and that the bus acknowledges only a special cycle that was actually requested. The stimulus respects all three: it raises `spc_ack` only while `spc_req` is observed high, and it holds the cache results constant across each snoop. The interrupt-priority property assumes that an interrupt pulse seen in sleep is acted on at once. For that reason, the bench never starts a flush or a snoop in the same cycle it tests wake priority without resetting afterwards. The bench also never drops `stpclk` while testing that an interrupt is held off during stop grant.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

   typedef enum logic [3:0] {
      HS_NORMAL     = 4'd0,
      HS_HALT_MSG   = 4'd1,
      HS_SLEEP      = 4'd2,
      HS_SNP_LOOK   = 4'd3,
      HS_SNP_RESP   = 4'd4,
      HS_FLUSH_WALK = 4'd5,
      HS_FLUSH_INV  = 4'd6,
      HS_STOP_GNT   = 4'd7,
      HS_WAKE       = 4'd8
   } hpc_state_e;

   typedef struct packed {
      logic irq;
      logic flush;
      logic snoop;
   } hpc_pend_t;

   function automatic logic hpc_is_gated(input hpc_state_e s);
      return (s == HS_SLEEP) || (s == HS_SNP_LOOK) || (s == HS_SNP_RESP) ||
             (s == HS_FLUSH_WALK) || (s == HS_FLUSH_INV) || (s == HS_STOP_GNT);
   endfunction

   function automatic logic hpc_latches_live(input hpc_state_e s);
      return (s != HS_NORMAL) && (s != HS_WAKE);
   endfunction

endpackage

// File: rtl/hpc_req_latch.sv
module hpc_req_latch
   import hpc_pkg::*;
#(
   parameter int NUM_EVT = 5,
   parameter int AW      = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               capture_en,
   input  logic [NUM_EVT-1:0] irq_evt,
   input  logic               snoop_req,
   input  logic [AW-1:0]      snoop_addr,
   input  logic               flush_req,
   input  logic               take_snoop,
   input  logic               take_flush,
   output hpc_pend_t          pend,
   output logic [AW-1:0]      snp_addr_q
);

   logic [NUM_EVT-1:0] irq_lat_q;
   logic               snp_lat_q;
   logic               fl_lat_q;

   generate
      if (NUM_EVT < 1) begin : g_bad_evt
         $error("hpc_req_latch: NUM_EVT must be at least 1");
      end
      if (AW < 1) begin : g_bad_aw
         $error("hpc_req_latch: AW must be at least 1");
      end
      for (genvar e = 0; e < NUM_EVT; e++) begin : g_irq
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_lat_q[e] <= 1'b0;
            end else if (!capture_en) begin
               irq_lat_q[e] <= 1'b0;
            end else if (irq_evt[e]) begin
               irq_lat_q[e] <= 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snp_lat_q <= 1'b0;
      end else if (!capture_en || take_snoop) begin
         snp_lat_q <= 1'b0;
      end else if (snoop_req) begin
         snp_lat_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         snp_addr_q <= '0;
      end else if (capture_en && snoop_req && !snp_lat_q) begin
         snp_addr_q <= snoop_addr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fl_lat_q <= 1'b0;
      end else if (!capture_en || take_flush) begin
         fl_lat_q <= 1'b0;
      end else if (flush_req) begin
         fl_lat_q <= 1'b1;
      end
   end

   always_comb begin
      pend.irq   = capture_en && (|(irq_lat_q | irq_evt));
      pend.flush = capture_en && (fl_lat_q || flush_req);
      pend.snoop = capture_en && (snp_lat_q || snoop_req);
   end

endmodule

// File: rtl/hpc_snoop_resp.sv
module hpc_snoop_resp #(
   parameter int NUM_CACHES = 3
) (
   input  logic                  look_act,
   input  logic                  resp_act,
   input  logic [NUM_CACHES-1:0] cache_hit,
   input  logic [NUM_CACHES-1:0] cache_hitm,
   output logic [NUM_CACHES-1:0] cache_lookup,
   output logic                  snp_rsp_vld,
   output logic                  snp_hit,
   output logic                  snp_hitm
);

   logic [NUM_CACHES-1:0] hit_gated;
   logic [NUM_CACHES-1:0] hitm_gated;

   generate
      if (NUM_CACHES < 1) begin : g_bad_caches
         $error("hpc_snoop_resp: NUM_CACHES must be at least 1");
      end
      for (genvar c = 0; c < NUM_CACHES; c++) begin : g_cache
         assign cache_lookup[c] = look_act;
         assign hit_gated[c]    = resp_act & cache_hit[c];
         assign hitm_gated[c]   = resp_act & cache_hitm[c];
      end
   endgenerate

   assign snp_rsp_vld = resp_act;
   assign snp_hit     = |hit_gated;
   assign snp_hitm    = |hitm_gated;

endmodule

// File: rtl/hpc_flush_seq.sv
module hpc_flush_seq #(
   parameter int LINES = 16,
   localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             walk_act,
   input  logic             line_dirty,
   output logic [IDX_W-1:0] flush_idx,
   output logic             wb_stb,
   output logic             walk_last
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(LINES - 1);

   logic [IDX_W-1:0] idx_q;

   generate
      if (LINES < 2) begin : g_bad_lines
         $error("hpc_flush_seq: LINES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
      end else if (walk_act && (idx_q != LAST_IDX)) begin
         idx_q <= idx_q + IDX_W'(1);
      end else begin
         idx_q <= '0;
      end
   end

   assign flush_idx = idx_q;
   assign wb_stb    = walk_act && line_dirty;
   assign walk_last = walk_act && (idx_q == LAST_IDX);

endmodule

// File: rtl/hpc_fsm.sv
module hpc_fsm
   import hpc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       halt_retire,
   input  logic       spc_ack,
   input  logic       smi_ret,
   input  logic       smi_ret_halt,
   input  logic       stpclk,
   input  hpc_pend_t  pend,
   input  logic       walk_last,
   output hpc_state_e st_q,
   output logic       take_snoop,
   output logic       take_flush
);

   hpc_state_e st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         HS_NORMAL: begin
            if (halt_retire) begin
               st_d = HS_HALT_MSG;
            end else if (smi_ret && smi_ret_halt) begin
               st_d = HS_SLEEP;
            end
         end
         HS_HALT_MSG: begin
            if (spc_ack) begin
               st_d = HS_SLEEP;
            end
         end
         HS_SLEEP: begin
            if (pend.irq) begin
               st_d = HS_WAKE;
            end else if (stpclk) begin
               st_d = HS_STOP_GNT;
            end else if (pend.flush) begin
               st_d = HS_FLUSH_WALK;
            end else if (pend.snoop) begin
               st_d = HS_SNP_LOOK;
            end
         end
         HS_SNP_LOOK:   st_d = HS_SNP_RESP;
         HS_SNP_RESP:   st_d = HS_SLEEP;
         HS_FLUSH_WALK: begin
            if (walk_last) begin
               st_d = HS_FLUSH_INV;
            end
         end
         HS_FLUSH_INV:  st_d = HS_SLEEP;
         HS_STOP_GNT: begin
            if (!stpclk) begin
               st_d = HS_SLEEP;
            end
         end
         HS_WAKE:       st_d = HS_NORMAL;
         default:       st_d = HS_NORMAL;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= HS_NORMAL;
      end else begin
         st_q <= st_d;
      end
   end

   assign take_snoop = (st_q == HS_SLEEP) && (st_d == HS_SNP_LOOK);
   assign take_flush = (st_q == HS_SLEEP) && (st_d == HS_FLUSH_WALK);

endmodule

// File: rtl/halt_pwr_ctrl.sv
module halt_pwr_ctrl
   import hpc_pkg::*;
#(
   parameter int NUM_EVT    = 5,
   parameter int NUM_CACHES = 3,
   parameter int LINES      = 16,
   parameter int AW         = 32,
   localparam int IDX_W     = (LINES > 1) ? $clog2(LINES) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  halt_retire,
   input  logic                  spc_ack,
   output logic                  spc_req,
   input  logic                  smi_ret,
   input  logic                  smi_ret_halt,
   input  logic [NUM_EVT-1:0]    irq_evt,
   input  logic                  stpclk,
   output logic                  stop_gnt,
   input  logic                  flush_req,
   output logic [IDX_W-1:0]      flush_idx,
   input  logic                  line_dirty,
   output logic                  wb_stb,
   output logic                  inval_all,
   input  logic                  snoop_req,
   input  logic [AW-1:0]         snoop_addr,
   output logic [NUM_CACHES-1:0] cache_lookup,
   output logic [AW-1:0]         lookup_addr,
   input  logic [NUM_CACHES-1:0] cache_hit,
   input  logic [NUM_CACHES-1:0] cache_hitm,
   output logic                  snp_rsp_vld,
   output logic                  snp_hit,
   output logic                  snp_hitm,
   output logic                  pwr_gate_en
);

   hpc_state_e st_q;
   hpc_pend_t  pend;
   logic       take_snoop;
   logic       take_flush;
   logic       walk_last;
   logic       capture_en;

   assign capture_en = hpc_latches_live(st_q);

   hpc_req_latch #(
      .NUM_EVT (NUM_EVT),
      .AW      (AW)
   ) u_latch (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture_en (capture_en),
      .irq_evt    (irq_evt),
      .snoop_req  (snoop_req),
      .snoop_addr (snoop_addr),
      .flush_req  (flush_req),
      .take_snoop (take_snoop),
      .take_flush (take_flush),
      .pend       (pend),
      .snp_addr_q (lookup_addr)
   );

   hpc_fsm u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .halt_retire  (halt_retire),
      .spc_ack      (spc_ack),
      .smi_ret      (smi_ret),
      .smi_ret_halt (smi_ret_halt),
      .stpclk       (stpclk),
      .pend         (pend),
      .walk_last    (walk_last),
      .st_q         (st_q),
      .take_snoop   (take_snoop),
      .take_flush   (take_flush)
   );

   hpc_flush_seq #(
      .LINES (LINES)
   ) u_flush (
      .clk        (clk),
      .rst_n      (rst_n),
      .walk_act   (st_q == HS_FLUSH_WALK),
      .line_dirty (line_dirty),
      .flush_idx  (flush_idx),
      .wb_stb     (wb_stb),
      .walk_last  (walk_last)
   );

   hpc_snoop_resp #(
      .NUM_CACHES (NUM_CACHES)
   ) u_snoop (
      .look_act     (st_q == HS_SNP_LOOK),
      .resp_act     (st_q == HS_SNP_RESP),
      .cache_hit    (cache_hit),
      .cache_hitm   (cache_hitm),
      .cache_lookup (cache_lookup),
      .snp_rsp_vld  (snp_rsp_vld),
      .snp_hit      (snp_hit),
      .snp_hitm     (snp_hitm)
   );

   assign spc_req     = (st_q == HS_HALT_MSG);
   assign stop_gnt    = (st_q == HS_STOP_GNT);
   assign inval_all   = (st_q == HS_FLUSH_INV);
   assign pwr_gate_en = hpc_is_gated(st_q);

endmodule

// File: rtl/hpc_chk.sv
module hpc_chk
   import hpc_pkg::*;
#(
   parameter int NUM_EVT    = 5,
   parameter int NUM_CACHES = 3
) (
   input logic                  clk,
   input logic                  rst_n,
   input hpc_state_e            st_q,
   input logic                  spc_req,
   input logic                  spc_ack,
   input logic                  smi_ret,
   input logic                  smi_ret_halt,
   input logic [NUM_EVT-1:0]    irq_evt,
   input logic                  stpclk,
   input logic                  stop_gnt,
   input logic                  wb_stb,
   input logic                  line_dirty,
   input logic                  inval_all,
   input logic [NUM_CACHES-1:0] cache_lookup,
   input logic                  snp_rsp_vld,
   input logic                  pwr_gate_en
);

   p_spc_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (spc_req && !spc_ack) |=> spc_req);

   p_no_gate_msg_r1: assert property (@(posedge clk) disable iff (!rst_n)
      spc_req |-> !pwr_gate_en);

   p_gate_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_gate_en) |-> ($past(spc_req && spc_ack) || $past(smi_ret && smi_ret_halt)));

   p_snoop_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (|cache_lookup) |=> (snp_rsp_vld && pwr_gate_en));

   p_rsp_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      snp_rsp_vld |-> $past(&cache_lookup));

   p_gate_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_gate_en) |-> (st_q == HS_WAKE));

   p_wake_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == HS_WAKE) |=> (st_q == HS_NORMAL));

   p_wb_dirty_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_stb |-> (line_dirty && pwr_gate_en));

   p_inval_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      inval_all |=> !inval_all);

   p_stop_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_gnt && stpclk) |=> stop_gnt);

   p_stop_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stop_gnt) |-> pwr_gate_en);

   p_irq_pri_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == HS_SLEEP) && (|irq_evt)) |=> (st_q == HS_WAKE));

   p_snoop_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == HS_SNP_LOOK) |=> (st_q == HS_SNP_RESP));

endmodule

bind halt_pwr_ctrl hpc_chk #(
   .NUM_EVT    (NUM_EVT),
   .NUM_CACHES (NUM_CACHES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .st_q         (st_q),
   .spc_req      (spc_req),
   .spc_ack      (spc_ack),
   .smi_ret      (smi_ret),
   .smi_ret_halt (smi_ret_halt),
   .irq_evt      (irq_evt),
   .stpclk       (stpclk),
   .stop_gnt     (stop_gnt),
   .wb_stb       (wb_stb),
   .line_dirty   (line_dirty),
   .inval_all    (inval_all),
   .cache_lookup (cache_lookup),
   .snp_rsp_vld  (snp_rsp_vld),
   .pwr_gate_en  (pwr_gate_en)
);

// File: tb/halt_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module halt_pwr_ctrl_tb;

   localparam int NE = 5;
   localparam int NC = 3;
   localparam int NL = 16;
   localparam int AW = 32;
   localparam int IW = $clog2(NL);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          halt_retire = 1'b0, spc_ack = 1'b0, spc_req;
   logic          smi_ret = 1'b0, smi_ret_halt = 1'b0;
   logic [NE-1:0] irq_evt = '0;
   logic          stpclk = 1'b0, stop_gnt;
   logic          flush_req = 1'b0, wb_stb, inval_all, line_dirty;
   logic [IW-1:0] flush_idx;
   logic          snoop_req = 1'b0;
   logic [AW-1:0] snoop_addr = '0, lookup_addr;
   logic [NC-1:0] cache_lookup, cache_hit = '0, cache_hitm = '0;
   logic          snp_rsp_vld, snp_hit, snp_hitm, pwr_gate_en;
   logic [NL-1:0] dirty_mask = '0;

   int n_checks = 0;
   int n_errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   assign line_dirty = dirty_mask[flush_idx];

   halt_pwr_ctrl #(.NUM_EVT(NE), .NUM_CACHES(NC), .LINES(NL), .AW(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .halt_retire(halt_retire), .spc_ack(spc_ack),
      .spc_req(spc_req), .smi_ret(smi_ret), .smi_ret_halt(smi_ret_halt),
      .irq_evt(irq_evt), .stpclk(stpclk), .stop_gnt(stop_gnt),
      .flush_req(flush_req), .flush_idx(flush_idx), .line_dirty(line_dirty),
      .wb_stb(wb_stb), .inval_all(inval_all), .snoop_req(snoop_req),
      .snoop_addr(snoop_addr), .cache_lookup(cache_lookup),
      .lookup_addr(lookup_addr), .cache_hit(cache_hit), .cache_hitm(cache_hitm),
      .snp_rsp_vld(snp_rsp_vld), .snp_hit(snp_hit), .snp_hitm(snp_hitm),
      .pwr_gate_en(pwr_gate_en)
   );

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      halt_retire = 0; spc_ack = 0; smi_ret = 0; smi_ret_halt = 0;
      irq_evt = '0; stpclk = 0; flush_req = 0; snoop_req = 0;
      tick(); tick();
      rst_n = 1'b1;
   endtask

   task automatic go_sleep(input int wait_cyc);
      halt_retire = 1'b1;
      tick();
      halt_retire = 1'b0;
      for (int w = 0; w < wait_cyc; w++) begin
         chk("R1", "spc_req held", spc_req, 1);
         chk("R1", "gates off while msg", pwr_gate_en, 0);
         tick();
      end
      chk("R1", "spc_req raised", spc_req, 1);
      spc_ack = 1'b1;
      tick();
      spc_ack = 1'b0;
      chk("R2", "gates on after ack", pwr_gate_en, 1);
      chk("R2", "spc_req dropped", spc_req, 0);
   endtask

   task automatic run_snoop(input logic [AW-1:0] a, input logic [NC-1:0] h,
                            input logic [NC-1:0] hm);
      cache_hit = h; cache_hitm = hm;
      snoop_req = 1'b1; snoop_addr = a;
      tick();
      snoop_req = 1'b0; snoop_addr = '0;
      chk("R4", "lookup strobe", cache_lookup, {NC{1'b1}});
      chk("R4", "lookup addr", lookup_addr, a);
      chk("R3", "gated in lookup", pwr_gate_en, 1);
      tick();
      chk("R4", "strobe one cycle", cache_lookup, 0);
      chk("R4", "rsp valid", snp_rsp_vld, 1);
      chk("R4", "hit or", snp_hit, |h);
      chk("R4", "hitm or", snp_hitm, |hm);
      tick();
      chk("R4", "back to sleep", {snp_rsp_vld, pwr_gate_en}, 2'b01);
   endtask

   task automatic run_flush(input logic [NL-1:0] m);
      dirty_mask = m;
      flush_req = 1'b1;
      tick();
      flush_req = 1'b0;
      for (int i = 0; i < NL; i++) begin
         chk("R7", "walk index", flush_idx, i);
         chk("R7", "wb only dirty", wb_stb, m[i]);
         chk("R3", "gated in flush", pwr_gate_en, 1);
         tick();
      end
      chk("R7", "inval pulse", {inval_all, wb_stb}, 2'b10);
      tick();
      chk("R7", "inval single, sleep", {inval_all, pwr_gate_en}, 2'b01);
   endtask

   initial begin
      do_reset();
      // R11: reset state
      chk("R11", "reset outputs",
          {spc_req, stop_gnt, wb_stb, inval_all, snp_rsp_vld, cache_lookup, pwr_gate_en}, 0);

      // R12: events in normal execution are ignored
      snoop_req = 1; flush_req = 1; irq_evt = 5'b00100;
      tick();
      snoop_req = 0; flush_req = 0; irq_evt = '0;
      tick();
      chk("R12", "no service in normal", {cache_lookup, wb_stb, pwr_gate_en}, 0);
      go_sleep(0);
      tick(); tick();
      chk("R12", "nothing served after sleep entry",
          {cache_lookup, snp_rsp_vld, wb_stb, inval_all, pwr_gate_en}, 1);

      // R1/R2: acknowledge delayed several cycles
      do_reset();
      go_sleep(4);

      // R4: exhaustive hit/hitm combinations
      for (int c = 0; c < 64; c++) begin
         run_snoop(32'hA000_0000 + c * 64, c[2:0], c[5:3]);
      end

      // R7: flush with several dirty patterns
      run_flush(16'h0000);
      run_flush(16'hFFFF);
      run_flush(16'h5555);
      run_flush(16'hAAAA);
      run_flush(16'h8001);
      for (int k = 1; k < 4; k++) run_flush(16'(k * 16'h3A97));

      // R8: stop grant held then released
      stpclk = 1'b1;
      tick();
      for (int i = 0; i < 5; i++) begin
         chk("R8", "stop_gnt held", {stop_gnt, pwr_gate_en}, 2'b11);
         tick();
      end
      stpclk = 1'b0;
      chk("R8", "still granted on drop cycle", stop_gnt, 1);
      tick();
      chk("R8", "stop released, asleep", {stop_gnt, pwr_gate_en}, 2'b01);

      // R5: each wake event
      for (int e = 0; e < NE; e++) begin
         do_reset();
         go_sleep(0);
         irq_evt = NE'(1) << e;
         tick();
         irq_evt = '0;
         chk("R5", "gates released", pwr_gate_en, 0);
         tick();
         chk("R5", "still released in normal", pwr_gate_en, 0);
         halt_retire = 1'b1;
         tick();
         halt_retire = 1'b0;
         chk("R5", "normal accepts halt", spc_req, 1);
      end

      // R6: handler return
      do_reset();
      smi_ret = 1; smi_ret_halt = 0;
      tick();
      smi_ret = 0;
      chk("R6", "return to normal", {spc_req, pwr_gate_en}, 2'b00);
      smi_ret = 1; smi_ret_halt = 1;
      tick();
      smi_ret = 0; smi_ret_halt = 0;
      chk("R6", "return lands in sleep", {spc_req, pwr_gate_en}, 2'b01);

      // R9: priority sweep
      dirty_mask = '1;
      for (int c = 0; c < 16; c++) begin
         logic [3:0] exp_code;
         do_reset();
         go_sleep(0);
         irq_evt = c[3] ? 5'b01000 : '0;
         stpclk = c[2]; flush_req = c[1]; snoop_req = c[0];
         tick();
         irq_evt = '0; stpclk = 0; flush_req = 0; snoop_req = 0;
         if (c[3])      exp_code = 4'b1000;
         else if (c[2]) exp_code = 4'b0100;
         else if (c[1]) exp_code = 4'b0010;
         else if (c[0]) exp_code = 4'b0001;
         else           exp_code = 4'b0000;
         chk("R9", "priority winner",
             {~pwr_gate_en, stop_gnt, wb_stb, |cache_lookup}, exp_code);
      end

      // R10: interrupt during snoop lookup
      do_reset();
      go_sleep(0);
      snoop_req = 1; snoop_addr = 32'h1234_5678;
      tick();
      snoop_req = 0;
      chk("R10", "in lookup", cache_lookup, {NC{1'b1}});
      irq_evt = 5'b00001;
      tick();
      irq_evt = '0;
      chk("R10", "response completes", {snp_rsp_vld, pwr_gate_en}, 2'b11);
      tick();
      chk("R10", "back in sleep first", {snp_rsp_vld, pwr_gate_en}, 2'b01);
      tick();
      chk("R10", "then wake", pwr_gate_en, 0);

      // R11: async reset and latch clearing
      do_reset();
      go_sleep(0);
      #5 rst_n = 1'b0;
      #1 chk("R11", "async gate release", {pwr_gate_en, spc_req}, 0);
      do_reset();
      halt_retire = 1;
      tick();
      halt_retire = 0;
      snoop_req = 1; flush_req = 1; snoop_addr = 32'hDEAD_0000;
      tick();
      snoop_req = 0; flush_req = 0;
      chk("R11", "requests latched in msg", spc_req, 1);
      do_reset();
      go_sleep(0);
      for (int i = 0; i < 4; i++) begin
         chk("R11", "latches cleared by reset", {cache_lookup, wb_stb, inval_all}, 0);
         tick();
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

endmodule